// File: doc/BRIEF.md
# Interleaved SAR Phase Sequencer

This block is the digital controller for a converter built from eight successive-approximation sections that take turns sampling one analog input. A single 4-bit phase counter runs on the master clock. Each section sees that count minus twice its own index, so the sections work through the same 16-step schedule two clocks apart. The schedule for one section has six parts in order: a reference-zero strobe, an offset-nulling compare strobe, a gain-trim compare strobe, an input-sample strobe, eleven bit-decision cycles and a transfer cycle. The block decodes the step of every section into per-section strobes for the analog side.

During the bit-decision cycles the block builds each section's 11-bit successive-approximation word from that section's comparator bit, starting at the MSB. In its transfer cycle a section's word passes through an 8:1 AND-OR selector. It is then rounded to 10 bits, saturated at full scale, and registered on the output. A data-available pulse marks each new word. An active-low output-enable input produces the drive enable for the output pads. The comparators, reference DACs and calibration loops lie outside this block.

Top module: `sar_phase_seq`

## Requirements
- R1: After a synchronous reset the phase count is 0 and advances by one per clock, modulo 16. Section s is at local step (count − 2·s) mod 16, and local step 15 of a section is followed by its local step 0. `rz_stb[s]` is high exactly in local step 0.
- R2: Per section, `az_stb` is high only in local step 1, `cal_stb` in step 2, `smp_stb` in step 3, `bit_stb` in steps 4 to 14 and `xfer_stb` in step 15.
- R3: On odd phase counts exactly one bit of `smp_stb` is high, and on even counts none is, so the input is sampled at half the clock rate.
- R4: In local step 4+k (k = 0..10) a section decides bit 10−k of its word. The bit is 1 when that section's `cmp` bit is high in that cycle. `cmp` has no effect outside steps 4 to 14.
- R5: `dout` changes only in the cycle after some section's transfer step. A word appears there 12 clock edges after the edge that closes its sample step.
- R6: The output word is straight binary: bits 10:1 of the section word plus bit 0, held at 1023 when bits 10:1 are already 1023.
- R7: `dav` is high for exactly the one cycle in which a new word first appears and is low otherwise. It stays low for words from sections that have not sampled since reset.
- R8: `dout_en` is high when `oe_n` is low and low when `oe_n` is high. `oe_n` does not alter `dout`, `dav` or the schedule.
- R9: While `rst` is high at a clock edge, the phase count, all section words, `dout` and `dav` return to zero, and the validity flags of all sections are cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock, twice the sample rate |
| rst | input | 1 | Synchronous reset, active high |
| oe_n | input | 1 | Output enable, active low |
| cmp | input | 8 | Comparator decision bit per section |
| dout | output | 10 | Registered output word, straight binary |
| dout_en | output | 1 | Pad drive enable for dout |
| dav | output | 1 | Data-available pulse |
| rz_stb | output | 8 | Reference-zero sample strobe per section |
| az_stb | output | 8 | Offset-nulling compare strobe per section |
| cal_stb | output | 8 | Gain-trim compare strobe per section |
| smp_stb | output | 8 | Input-sample strobe per section |
| bit_stb | output | 8 | Bit-decision cycle strobe per section |
| xfer_stb | output | 8 | Transfer strobe per section |

## Verification
The checker relies on reset being asserted for at least one edge before any check counts. Every timing relation is measured from the first cycle after reset, using a counter of edges since reset rather than history from before it. The checker also assumes that `cmp` carries a decision only in a section's bit cycles. The stimulus serves the comparator bits from an input code that is latched in each section's sample step. It drives alternating junk on `cmp` in all other steps, so a design that listens outside its bit cycles produces wrong words. Input codes change only every second clock, so each code is captured by exactly one section.

// File: rtl/sar_phase_seq.sv
module sar_phase_seq #(
  parameter int NSEC = 8,
  parameter int STAG = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            oe_n,
  input  logic [NSEC-1:0] cmp,
  output logic [NSEC+STAG*NSEC-15:0] dout,
  output logic            dout_en,
  output logic            dav,
  output logic [NSEC-1:0] rz_stb,
  output logic [NSEC-1:0] az_stb,
  output logic [NSEC-1:0] cal_stb,
  output logic [NSEC-1:0] smp_stb,
  output logic [NSEC-1:0] bit_stb,
  output logic [NSEC-1:0] xfer_stb
);
  localparam int NPH   = NSEC * STAG;
  localparam int PW    = $clog2(NPH);
  localparam int SBITS = NPH - 5;
  localparam int OBITS = SBITS - 1;
  localparam int S_SMP = 3;
  localparam int S_XF  = NPH - 1;

  logic [PW-1:0]                ph;
  logic [NSEC-1:0][PW-1:0]      st;
  logic [NSEC-1:0][SBITS-1:0]   sar;
  logic [NSEC-1:0]              vld;
  logic [SBITS-1:0]             picked;
  logic                         pv;
  logic [OBITS-1:0]             up, word, q;
  logic                         dav_q;

  for (genvar s = 0; s < NSEC; s++) begin : g_sec
    assign st[s]       = ph - PW'(STAG * s);
    assign rz_stb[s]   = st[s] == PW'(0);
    assign az_stb[s]   = st[s] == PW'(1);
    assign cal_stb[s]  = st[s] == PW'(2);
    assign smp_stb[s]  = st[s] == PW'(S_SMP);
    assign bit_stb[s]  = st[s] > PW'(S_SMP) && st[s] < PW'(S_XF);
    assign xfer_stb[s] = st[s] == PW'(S_XF);
  end

  always_comb begin
    picked = '0;
    pv     = 1'b0;
    for (int s = 0; s < NSEC; s++) begin
      picked = picked | (sar[s] & {SBITS{xfer_stb[s]}});
      pv     = pv | (vld[s] & xfer_stb[s]);
    end
  end

  assign up   = picked[SBITS-1:1];
  assign word = (&up) ? up : up + OBITS'(picked[0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph    <= '0;
      sar   <= '0;
      vld   <= '0;
      q     <= '0;
      dav_q <= 1'b0;
    end else begin
      ph <= ph + 1'b1;
      for (int s = 0; s < NSEC; s++) begin
        if (smp_stb[s]) begin
          sar[s] <= '0;
          vld[s] <= 1'b1;
        end else if (bit_stb[s] && cmp[s]) begin
          sar[s] <= sar[s] | (SBITS'(1) << (PW'(S_XF - 1) - st[s]));
        end
      end
      if (|xfer_stb) begin
        q     <= word;
        dav_q <= pv;
      end else begin
        dav_q <= 1'b0;
      end
    end
  end

  assign dout    = q;
  assign dav     = dav_q;
  assign dout_en = ~oe_n;
endmodule

// File: rtl/sar_phase_seq_chk.sv
module sar_phase_seq_chk #(
  parameter int NSEC = 8,
  parameter int STAG = 2
) (
  input logic            clk,
  input logic            rst,
  input logic [NSEC+STAG*NSEC-15:0] dout,
  input logic            dav,
  input logic [NSEC-1:0] rz_stb,
  input logic [NSEC-1:0] az_stb,
  input logic [NSEC-1:0] cal_stb,
  input logic [NSEC-1:0] smp_stb,
  input logic [NSEC-1:0] xfer_stb
);
  localparam int LAT = NSEC * STAG - 4;

  int age;
  logic [LAT-1:0][NSEC-1:0] dl;

  always_ff @(posedge clk) begin
    if (rst) begin
      age <= 0;
      dl  <= '0;
    end else begin
      if (age < LAT) age <= age + 1;
      dl <= {dl[LAT-2:0], smp_stb};
    end
  end

  p_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    (age != 0) |-> rz_stb == $past(xfer_stb));

  p_order_r2: assert property (@(posedge clk) disable iff (rst)
    (age != 0) |-> (az_stb == $past(rz_stb)) && (cal_stb == $past(az_stb))
                   && (smp_stb == $past(cal_stb)));

  p_one_sampler_r3: assert property (@(posedge clk) disable iff (rst)
    (age != 0) |-> ($countones(smp_stb) + $countones($past(smp_stb))) == 1);

  p_latency_r5: assert property (@(posedge clk) disable iff (rst)
    (age >= LAT) |-> xfer_stb == dl[LAT-1]);

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (age != 0 && !$past(|xfer_stb)) |-> $stable(dout));

  p_dav_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    dav |=> !dav);

  p_dav_src_r7: assert property (@(posedge clk) disable iff (rst)
    (age != 0 && dav) |-> $past(|xfer_stb));
endmodule

bind sar_phase_seq sar_phase_seq_chk #(.NSEC(NSEC), .STAG(STAG)) u_chk (
  .clk(clk), .rst(rst), .dout(dout), .dav(dav), .rz_stb(rz_stb),
  .az_stb(az_stb), .cal_stb(cal_stb), .smp_stb(smp_stb), .xfer_stb(xfer_stb)
);

// File: tb/sar_phase_seq_bench.sv
module sar_phase_seq_bench;
  localparam int NV = 16;
  localparam logic [20:0] VEC [NV] = '{
    {11'h7FF, 10'h3FF}, {11'h000, 10'h000}, {11'h7FE, 10'h3FF}, {11'h001, 10'h001},
    {11'h7FD, 10'h3FF}, {11'h002, 10'h001}, {11'h7FC, 10'h3FE}, {11'h003, 10'h002},
    {11'h400, 10'h200}, {11'h3FF, 10'h200}, {11'h401, 10'h201}, {11'h2AA, 10'h155},
    {11'h555, 10'h2AB}, {11'h123, 10'h092}, {11'h0FE, 10'h07F}, {11'h6B5, 10'h35B}
  };

  logic clk = 1'b0, rst = 1'b1, oe_n = 1'b0;
  logic [7:0] cmp = '0;
  logic [9:0] dout;
  logic dout_en, dav;
  logic [7:0] rz, az, cal, smp, bits, xf;

  sar_phase_seq u_sar_phase_seq (
    .clk(clk), .rst(rst), .oe_n(oe_n), .cmp(cmp), .dout(dout), .dout_en(dout_en),
    .dav(dav), .rz_stb(rz), .az_stb(az), .cal_stb(cal), .smp_stb(smp),
    .bit_stb(bits), .xfer_stb(xf)
  );

  always #10 clk = ~clk;

  int checks = 0, bad = 0, bph = 0;
  bit done = 1'b0;
  logic [10:0] held [8];
  logic [9:0]  hexp [8];
  logic        hv   [8];
  logic [10:0] ain = '0;
  logic [9:0]  aexp = '0, last_exp = '0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s at phase %0d: act=%0h exp=%0h", req, bph, act, exp);
    end
  endtask

  task automatic model_reset();
    bph = 0;
    last_exp = '0;
    for (int s = 0; s < 8; s++) begin held[s] = '0; hexp[s] = '0; hv[s] = 1'b0; end
  endtask

  task automatic observe();
    logic [7:0] er, ea, ec, es, eb, ex;
    int s0;
    for (int s = 0; s < 8; s++) begin
      int st = (bph - 2 * s) & 15;
      er[s] = st == 0;  ea[s] = st == 1;  ec[s] = st == 2;
      es[s] = st == 3;  eb[s] = st >= 4 && st <= 14;  ex[s] = st == 15;
    end
    chk(rz == er, "R1 ref-zero strobe", 64'(rz), 64'(er));
    chk({az, cal, bits, xf} == {ea, ec, eb, ex}, "R2 strobe schedule",
        64'({az, cal, bits, xf}), 64'({ea, ec, eb, ex}));
    chk(smp == es && $countones(smp) == (bph & 1), "R3 one sampler", 64'(smp), 64'(es));
    s0 = (bph & 15) / 2;
    if (bph > 0 && (bph & 1) == 0) last_exp = hv[s0] ? hexp[s0] : 10'h000;
    chk(dout == last_exp, "R4 R5 R6 output word", 64'(dout), 64'(last_exp));
    chk(dav == (bph > 0 && (bph & 1) == 0 && hv[s0]), "R7 data-available",
        64'(dav), 64'(bph > 0 && (bph & 1) == 0 && hv[s0]));
    chk(dout_en == !oe_n, "R8 drive enable", 64'(dout_en), 64'(!oe_n));
  endtask

  task automatic drive();
    for (int s = 0; s < 8; s++) begin
      int st = (bph - 2 * s) & 15;
      if (st == 3) begin held[s] = ain; hexp[s] = aexp; hv[s] = 1'b1; end
      if (st >= 4 && st <= 14) cmp[s] = held[s][14 - st];
      else cmp[s] = 1'((bph ^ s) & 1);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    bph++;
    observe();
    drive();
  endtask

  task automatic release_rst();
    @(negedge clk);
    rst = 1'b0;
    model_reset();
    observe();
    drive();
  endtask

  task automatic reset_checks();
    @(negedge clk);
    chk(dav == 1'b0, "R9 dav in reset", 64'(dav), 64'd0);
    chk(dout == 10'h000, "R9 dout in reset", 64'(dout), 64'd0);
    chk(rz == 8'h01 && smp == 8'h00, "R9 phase zero in reset", 64'({rz, smp}), 64'h0100);
  endtask

  task automatic run_vectors(input bit reverse);
    for (int i = 0; i < NV; i++) begin
      int k = reverse ? NV - 1 - i : i;
      oe_n = (i >= 5 && i <= 7);
      {ain, aexp} = VEC[k];
      cyc();
      cyc();
    end
    oe_n = 1'b0;
    ain = 11'h555; aexp = 10'h2AB;
    for (int i = 0; i < 20; i++) cyc();
  endtask

  initial begin
    rst = 1'b1;
    repeat (2) @(negedge clk);
    reset_checks();
    release_rst();
    run_vectors(1'b0);
    rst = 1'b1;
    repeat (2) reset_checks();
    release_rst();
    run_vectors(1'b1);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      bad++;
      $display("FAIL watchdog: act=running exp=finished");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule